// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the coherence keeper for the slice of main memory that lives in one node of a distributed shared-memory machine. Each cache block of that slice has one directory entry, which records whether the block is uncached, shared, or modified. The entry also holds a presence vector with one bit per processor. Processors send read-miss, write-miss and write-back requests to the home node. The controller answers with point-to-point messages: data replies, invalidates, and fetches to the current owner. Each message carries a destination processor number. Nothing is broadcast.

The controller serves one request at a time. While it waits for the invalidate acknowledgements of a write miss, or for the data an owner returns to a fetch, it drops its ready signal. Requests whose address belongs to another node's memory slice are accepted but have no effect. The block data of the slice is held inside the controller, so replies and write-backs act on it directly.

Top module: `dir_home_top`

## Requirements
- R1: After reset, `reqReady` is 1 and `msgValid` is 0, every entry is uncached with no presence bit set, and block i of the slice holds the value i.
- R2: A request is ignored when its address node field (upper `NODE_W` bits of `reqAddr`) differs from `HOME_ID`, or when its type is 3. Ignored means no message is sent and no entry or data changes.
- R3: A read miss (type 0) to an uncached or shared block gets one data reply (message type 0) to the requester carrying the stored block value. The requester's presence bit is added and the entry becomes shared.
- R4: A write miss (type 1) to an uncached block gets a data reply with the stored value. The entry becomes modified with only the requester present.
- R5: A write miss to a shared block sends exactly one invalidate (message type 1) to each present processor other than the requester, and none to any other processor. After that, the entry is modified with only the requester present.
- R6: From accepting a request until its last message is issued, `reqReady` stays low. In particular, it stays low while any invalidate is unacknowledged or a fetch is unanswered. A write miss to a shared block sends its data reply only after all its invalidates are acknowledged.
- R7: A read miss to a modified block sends a fetch (message type 2) to the owner. When `fetchValid` arrives, the controller stores `fetchData`, replies with it to the requester, and leaves the entry shared with owner and requester present.
- R8: A write miss to a modified block sends a fetch to the owner, stores the returned data, and replies with it. The entry is then modified with only the requester present.
- R9: A write-back (type 2) from the owner of a modified block stores `reqData` and returns the entry to uncached with no presence bits. A write-back from any other processor, or to a block that is not modified, is ignored.
- R10: Every message carries in `msgAddr` the full request address it belongs to, and `msgType` is never 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and accepting a request |
| reqType | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 none |
| reqSrc | input | PROC_W | Requesting processor number |
| reqAddr | input | NODE_W+BLK_W | Node field above block index |
| reqData | input | DATA_W | Write-back data |
| ackValid | input | 1 | One invalidate acknowledgement |
| fetchValid | input | 1 | Owner's answer to a fetch |
| fetchData | input | DATA_W | Block data from the owner |
| msgValid | output | 1 | Outgoing message present for one cycle |
| msgType | output | 2 | 0 data reply, 1 invalidate, 2 fetch |
| msgDest | output | PROC_W | Destination processor |
| msgAddr | output | NODE_W+BLK_W | Address the message refers to |
| msgData | output | DATA_W | Block data of a data reply |

## Verification
The hardest case to reach from the ports is a write miss that lands on a block shared by several processors. The block must first be read by a changing set of processors, and the acknowledgements must then trickle back while invalidates are still being issued. The random stimulus confines most requests to four blocks and four processors, so sharer sets of two and three build up quickly. The bench's responder returns acknowledgements with a gap of several cycles, so the acknowledgement counter and the hold-off are exercised across the send and wait phases. Write-backs are steered to the true owner half of the time, so that both the accepted and the ignored write-back paths occur often.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    ST_UNC = 2'd0,
    ST_SHR = 2'd1,
    ST_MOD = 2'd2
  } dirState_e;

  localparam logic [1:0] REQ_READ  = 2'd0;
  localparam logic [1:0] REQ_WRITE = 2'd1;
  localparam logic [1:0] REQ_WB    = 2'd2;
  localparam logic [1:0] REQ_NONE  = 2'd3;

  localparam logic [1:0] MSG_DATA  = 2'd0;
  localparam logic [1:0] MSG_INV   = 2'd1;
  localparam logic [1:0] MSG_FETCH = 2'd2;

  typedef struct packed {
    logic latchReq;
    logic scanStart;
    logic scanStep;
    logic sendInv;
    logic sendFetch;
    logic sendData;
    logic dataFromFetch;
    logic updRead;
    logic updWrite;
    logic updWb;
  } dirStrobes_t;

  typedef struct packed {
    dirState_e  state;
    logic       isLocal;
    logic [1:0] kind;
    logic       srcPresent;
    logic       scanLast;
    logic       scanHit;
    logic       pendZero;
    logic       fetchArrived;
  } dirStatus_t;

endpackage

// File: rtl/dir_control.sv
module dir_control
  import dir_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  dirStatus_t  stat,
  output dirStrobes_t strb,
  output logic        reqReady
);

  typedef enum logic [2:0] {
    C_IDLE,
    C_DECIDE,
    C_SCAN,
    C_WAIT_ACK,
    C_WAIT_FETCH
  } ctrlState_e;

  ctrlState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= C_IDLE;
    else       state <= nextState;
  end

  assign reqReady = (state == C_IDLE);

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      C_IDLE: begin
        if (reqValid) begin
          strb.latchReq = 1'b1;
          nextState     = C_DECIDE;
        end
      end
      C_DECIDE: begin
        nextState = C_IDLE;
        if (stat.isLocal) begin
          case (stat.kind)
            REQ_READ: begin
              if (stat.state == ST_MOD) begin
                strb.sendFetch = 1'b1;
                nextState      = C_WAIT_FETCH;
              end else begin
                strb.sendData = 1'b1;
                strb.updRead  = 1'b1;
              end
            end
            REQ_WRITE: begin
              if (stat.state == ST_MOD) begin
                strb.sendFetch = 1'b1;
                nextState      = C_WAIT_FETCH;
              end else if (stat.state == ST_SHR) begin
                strb.scanStart = 1'b1;
                nextState      = C_SCAN;
              end else begin
                strb.sendData = 1'b1;
                strb.updWrite = 1'b1;
              end
            end
            REQ_WB: begin
              if (stat.state == ST_MOD && stat.srcPresent) strb.updWb = 1'b1;
            end
            default: ;
          endcase
        end
      end
      C_SCAN: begin
        strb.scanStep = 1'b1;
        strb.sendInv  = stat.scanHit;
        if (stat.scanLast) nextState = C_WAIT_ACK;
      end
      C_WAIT_ACK: begin
        if (stat.pendZero) begin
          strb.sendData = 1'b1;
          strb.updWrite = 1'b1;
          nextState     = C_IDLE;
        end
      end
      C_WAIT_FETCH: begin
        if (stat.fetchArrived) begin
          strb.sendData      = 1'b1;
          strb.dataFromFetch = 1'b1;
          if (stat.kind == REQ_READ) strb.updRead = 1'b1;
          else                       strb.updWrite = 1'b1;
          nextState = C_IDLE;
        end
      end
      default: nextState = C_IDLE;
    endcase
  end

endmodule

// File: rtl/dir_datapath.sv
module dir_datapath
  import dir_pkg::*;
#(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_BLOCKS = 16,
  parameter int DATA_W     = 16,
  parameter int NODE_W     = 2,
  parameter int HOME_ID    = 1,
  localparam int PROC_W = $clog2(NUM_PROCS),
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int ADDR_W = NODE_W + BLK_W,
  localparam int CNT_W  = $clog2(NUM_PROCS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dirStrobes_t       strb,
  input  logic [1:0]        reqType,
  input  logic [PROC_W-1:0] reqSrc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              ackValid,
  input  logic              fetchValid,
  input  logic [DATA_W-1:0] fetchData,
  output dirStatus_t        stat,
  output logic              msgValid,
  output logic [1:0]        msgType,
  output logic [PROC_W-1:0] msgDest,
  output logic [ADDR_W-1:0] msgAddr,
  output logic [DATA_W-1:0] msgData,
  output dirState_e         curState,
  output logic [NUM_PROCS-1:0] curPres,
  output logic [CNT_W-1:0]  pendCnt,
  output logic [PROC_W-1:0] latSrc
);

  logic [1:0]          latKind;
  logic [ADDR_W-1:0]   latAddr;
  logic [DATA_W-1:0]   latData;
  logic [PROC_W-1:0]   scanIdx;
  logic [PROC_W-1:0]   ownerIdx;
  logic [BLK_W-1:0]    blkIdx;
  logic [NUM_PROCS-1:0] srcBit;
  logic [DATA_W-1:0]   curMem;

  dirState_e            entryState [NUM_BLOCKS];
  logic [NUM_PROCS-1:0] entryPres  [NUM_BLOCKS];
  logic [DATA_W-1:0]    blockMem   [NUM_BLOCKS];

  assign blkIdx   = latAddr[BLK_W-1:0];
  assign srcBit   = NUM_PROCS'(1) << latSrc;
  assign curState = entryState[blkIdx];
  assign curPres  = entryPres[blkIdx];
  assign curMem   = blockMem[blkIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latKind <= REQ_NONE;
      latSrc  <= '0;
      latAddr <= '0;
      latData <= '0;
    end else if (strb.latchReq) begin
      latKind <= reqType;
      latSrc  <= reqSrc;
      latAddr <= reqAddr;
      latData <= reqData;
    end
  end

  // lowest present processor is taken as owner (single bit when modified)
  always_comb begin
    ownerIdx = '0;
    for (int i = NUM_PROCS - 1; i >= 0; i--) begin
      if (curPres[i]) ownerIdx = PROC_W'(i);
    end
  end

  genvar b;
  generate
    for (b = 0; b < NUM_BLOCKS; b++) begin : g_entry
      logic sel;
      assign sel = (blkIdx == BLK_W'(b));
      always_ff @(posedge clk) begin
        if (!rstN) begin
          entryState[b] <= ST_UNC;
          entryPres[b]  <= '0;
          blockMem[b]   <= DATA_W'(b);
        end else if (sel) begin
          if (strb.updRead) begin
            entryState[b] <= ST_SHR;
            entryPres[b]  <= entryPres[b] | srcBit;
          end
          if (strb.updWrite) begin
            entryState[b] <= ST_MOD;
            entryPres[b]  <= srcBit;
          end
          if (strb.updWb) begin
            entryState[b] <= ST_UNC;
            entryPres[b]  <= entryPres[b] & ~srcBit;
            blockMem[b]   <= latData;
          end
          if (strb.dataFromFetch) blockMem[b] <= fetchData;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)               scanIdx <= '0;
    else if (strb.scanStart) scanIdx <= '0;
    else if (strb.scanStep)  scanIdx <= scanIdx + 1'b1;
  end

  logic ackTake;
  assign ackTake = ackValid && (pendCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) pendCnt <= '0;
    else       pendCnt <= pendCnt + CNT_W'(strb.sendInv) - CNT_W'(ackTake);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgValid <= 1'b0;
      msgType  <= MSG_DATA;
      msgDest  <= '0;
      msgAddr  <= '0;
      msgData  <= '0;
    end else begin
      msgValid <= strb.sendInv | strb.sendFetch | strb.sendData;
      msgAddr  <= latAddr;
      msgData  <= '0;
      msgType  <= MSG_DATA;
      msgDest  <= latSrc;
      if (strb.sendInv) begin
        msgType <= MSG_INV;
        msgDest <= scanIdx;
      end else if (strb.sendFetch) begin
        msgType <= MSG_FETCH;
        msgDest <= ownerIdx;
      end else if (strb.sendData) begin
        msgData <= strb.dataFromFetch ? fetchData : curMem;
      end
    end
  end

  assign stat.state        = curState;
  assign stat.isLocal      = (latAddr[ADDR_W-1:BLK_W] == NODE_W'(HOME_ID));
  assign stat.kind         = latKind;
  assign stat.srcPresent   = curPres[latSrc];
  assign stat.scanLast     = (scanIdx == PROC_W'(NUM_PROCS - 1));
  assign stat.scanHit      = curPres[scanIdx] && (scanIdx != latSrc);
  assign stat.pendZero     = (pendCnt == '0);
  assign stat.fetchArrived = fetchValid;

endmodule

// File: rtl/dir_home_top.sv
module dir_home_top
  import dir_pkg::*;
#(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_BLOCKS = 16,
  parameter int DATA_W     = 16,
  parameter int NODE_W     = 2,
  parameter int HOME_ID    = 1,
  localparam int PROC_W = $clog2(NUM_PROCS),
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int ADDR_W = NODE_W + BLK_W,
  localparam int CNT_W  = $clog2(NUM_PROCS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqType,
  input  logic [PROC_W-1:0] reqSrc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              ackValid,
  input  logic              fetchValid,
  input  logic [DATA_W-1:0] fetchData,
  output logic              msgValid,
  output logic [1:0]        msgType,
  output logic [PROC_W-1:0] msgDest,
  output logic [ADDR_W-1:0] msgAddr,
  output logic [DATA_W-1:0] msgData
);

  dirStrobes_t          strb;
  dirStatus_t           stat;
  dirState_e            curState;
  logic [NUM_PROCS-1:0] curPres;
  logic [CNT_W-1:0]     pendCnt;
  logic [PROC_W-1:0]    latSrc;

  dir_control i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .stat     (stat),
    .strb     (strb),
    .reqReady (reqReady)
  );

  dir_datapath #(
    .NUM_PROCS  (NUM_PROCS),
    .NUM_BLOCKS (NUM_BLOCKS),
    .DATA_W     (DATA_W),
    .NODE_W     (NODE_W),
    .HOME_ID    (HOME_ID)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqType    (reqType),
    .reqSrc     (reqSrc),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .ackValid   (ackValid),
    .fetchValid (fetchValid),
    .fetchData  (fetchData),
    .stat       (stat),
    .msgValid   (msgValid),
    .msgType    (msgType),
    .msgDest    (msgDest),
    .msgAddr    (msgAddr),
    .msgData    (msgData),
    .curState   (curState),
    .curPres    (curPres),
    .pendCnt    (pendCnt),
    .latSrc     (latSrc)
  );

endmodule

// File: rtl/dir_home_checker.sv
module dir_home_checker #(
  parameter int NUM_PROCS = 4,
  parameter int PROC_W    = 2,
  parameter int CNT_W     = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqReady,
  input logic                 msgValid,
  input logic [1:0]           msgType,
  input logic [PROC_W-1:0]    msgDest,
  input logic [1:0]           curState,
  input logic [NUM_PROCS-1:0] curPres,
  input logic [CNT_W-1:0]     pendCnt,
  input logic [PROC_W-1:0]    latSrc
);

  a_r6_hold_while_pending: assert property (@(posedge clk) disable iff (!rstN)
    (pendCnt != '0) |-> !reqReady);

  a_r5_inv_skips_requester: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgType == 2'd1) |-> (msgDest != latSrc));

  a_r5_pend_bounded: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt < CNT_W'(NUM_PROCS));

  a_r8_modified_single_owner: assert property (@(posedge clk) disable iff (!rstN)
    (curState == 2'd2) |-> ($countones(curPres) == 1));

  a_r9_uncached_no_sharers: assert property (@(posedge clk) disable iff (!rstN)
    (curState == 2'd0) |-> (curPres == '0));

  a_r10_legal_msg_type: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgType != 2'd3));

endmodule

bind dir_home_top dir_home_checker #(
  .NUM_PROCS (NUM_PROCS),
  .PROC_W    (PROC_W),
  .CNT_W     (CNT_W)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .msgValid (msgValid),
  .msgType  (msgType),
  .msgDest  (msgDest),
  .curState (curState),
  .curPres  (curPres),
  .pendCnt  (pendCnt),
  .latSrc   (latSrc)
);

// File: tb/test_dir_home_top.sv
module test_dir_home_top;

  localparam int NP = 4;
  localparam int NB = 16;
  localparam int DW = 16;
  localparam int HOME = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqType = 2'd0;
  logic [1:0]  reqSrc = 2'd0;
  logic [5:0]  reqAddr = 6'd0;
  logic [15:0] reqData = 16'd0;
  logic        ackValid = 1'b0;
  logic        fetchValid = 1'b0;
  logic [15:0] fetchData = 16'd0;
  logic        msgValid;
  logic [1:0]  msgType;
  logic [1:0]  msgDest;
  logic [5:0]  msgAddr;
  logic [15:0] msgData;

  dir_home_top i_dir_home_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqType(reqType), .reqSrc(reqSrc), .reqAddr(reqAddr), .reqData(reqData),
    .ackValid(ackValid), .fetchValid(fetchValid), .fetchData(fetchData),
    .msgValid(msgValid), .msgType(msgType), .msgDest(msgDest),
    .msgAddr(msgAddr), .msgData(msgData)
  );

  always #10 clk = ~clk;

  int nChecks = 0;
  int nErrors = 0;

  // reference model of the directory
  int mState [NB];
  int mPres  [NB];
  int mMem   [NB];

  // observed message record
  int dataCnt, dataDest, dataVal, invCnt, invMask, fetchCnt, fetchDest;
  bit addrBad, holdBad;
  logic [5:0] curAddr;
  int toAck = 0, ackWait = 0, fetchCd = 0;
  logic [15:0] fetchVal = 16'd0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (msgValid) begin
      if (msgAddr != curAddr) addrBad = 1'b1;
      case (msgType)
        2'd0: begin dataCnt++; dataDest = int'(msgDest); dataVal = int'(msgData); end
        2'd1: begin invCnt++; invMask |= (1 << msgDest); toAck++; end
        2'd2: begin fetchCnt++; fetchDest = int'(msgDest); fetchCd = 3; end
        default: addrBad = 1'b1;
      endcase
    end
    if ((toAck > 0 || fetchCd > 0) && reqReady) holdBad = 1'b1;
    ackValid = 1'b0;
    if (toAck > 0) begin
      if (ackWait == 0) begin ackValid = 1'b1; toAck--; ackWait = 2; end
      else ackWait--;
    end
    fetchValid = 1'b0;
    if (fetchCd > 0) begin
      fetchCd--;
      if (fetchCd == 0) begin fetchValid = 1'b1; fetchData = fetchVal; end
    end
  end

  function automatic int ownerOf(input int pres);
    for (int i = 0; i < NP; i++) if (pres[i]) return i;
    return 0;
  endfunction

  task automatic doReq(input int kind, input int src, input int node, input int blk,
                       input logic [15:0] wb);
    int eData, eDest, eFetch, eInv, bitv, cyc;
    string tg;
    @(negedge clk);
    dataCnt = 0; dataDest = -1; dataVal = -1; invCnt = 0; invMask = 0;
    fetchCnt = 0; fetchDest = -1; addrBad = 0; holdBad = 0;
    fetchVal = 16'($urandom);
    curAddr = {2'(node), 4'(blk)};
    reqValid = 1'b1; reqType = 2'(kind); reqSrc = 2'(src);
    reqAddr = curAddr; reqData = wb;
    @(negedge clk);
    reqValid = 1'b0;
    cyc = 0;
    while (!reqReady && cyc < 300) begin @(negedge clk); cyc++; end
    chk(cyc < 300, "R6", cyc, 300);
    @(negedge clk);
    // expected from model
    eData = -1; eDest = -1; eFetch = -1; eInv = 0; bitv = 1 << src; tg = "R2";
    if (node == HOME && kind != 3) begin
      case (kind)
        0: if (mState[blk] == 2) begin
             tg = "R7"; eFetch = ownerOf(mPres[blk]); eDest = src; eData = int'(fetchVal);
             mMem[blk] = int'(fetchVal); mPres[blk] |= bitv; mState[blk] = 1;
           end else begin
             tg = "R3"; eDest = src; eData = mMem[blk]; mPres[blk] |= bitv; mState[blk] = 1;
           end
        1: begin
             if (mState[blk] == 2) begin
               tg = "R8"; eFetch = ownerOf(mPres[blk]); eDest = src; eData = int'(fetchVal);
               mMem[blk] = int'(fetchVal);
             end else if (mState[blk] == 1) begin
               tg = "R5"; eInv = mPres[blk] & ~bitv; eDest = src; eData = mMem[blk];
             end else begin
               tg = "R4"; eDest = src; eData = mMem[blk];
             end
             mPres[blk] = bitv; mState[blk] = 2;
           end
        default: begin
             tg = "R9";
             if (mState[blk] == 2 && (mPres[blk] & bitv) != 0) begin
               mMem[blk] = int'(wb); mPres[blk] = 0; mState[blk] = 0;
             end
           end
      endcase
    end
    chk(invMask == eInv, tg, invMask, eInv);
    chk(invCnt == $countones(eInv), tg, invCnt, $countones(eInv));
    chk(fetchCnt == (eFetch >= 0 ? 1 : 0), tg, fetchCnt, eFetch >= 0 ? 1 : 0);
    if (eFetch >= 0) chk(fetchDest == eFetch, tg, fetchDest, eFetch);
    chk(dataCnt == (eDest >= 0 ? 1 : 0), tg, dataCnt, eDest >= 0 ? 1 : 0);
    if (eDest >= 0) begin
      chk(dataDest == eDest, tg, dataDest, eDest);
      chk(dataVal == eData, tg, dataVal, eData);
    end
    chk(!addrBad, "R10", int'(addrBad), 0);
    chk(!holdBad, "R6", int'(holdBad), 0);
  endtask

  initial begin
    #(20 * 200000);
    nErrors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    int seedDummy, kind, src, blk, node;
    seedDummy = $urandom(32'd20240611);
    for (int i = 0; i < NB; i++) begin mState[i] = 0; mPres[i] = 0; mMem[i] = i; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1", int'(reqReady), 1);
    chk(msgValid == 1'b0, "R1", int'(msgValid), 0);

    // directed corner cases
    doReq(0, 0, HOME, 2, 16'h0);            // R3 first read
    chk(dataVal == 2, "R1", dataVal, 2);    // R1 reset content
    doReq(0, 1, HOME, 2, 16'h0);
    doReq(0, 3, HOME, 2, 16'h0);
    doReq(1, 1, HOME, 2, 16'h0);            // R5 invalidates to 0 and 3
    chk(invMask == 32'h9, "R5", invMask, 9);
    doReq(0, 2, HOME, 2, 16'h0);            // R7 fetch from 1
    doReq(1, 0, HOME, 2, 16'h0);            // R5 invalidates to 1 and 2
    doReq(1, 3, HOME, 2, 16'h0);            // R8 fetch from 0
    doReq(2, 1, HOME, 2, 16'h1111);         // R9 non-owner ignored
    doReq(2, 3, HOME, 2, 16'hBEEF);         // R9 owner write-back
    doReq(0, 0, HOME, 2, 16'h0);            // R3 sees written-back data
    chk(dataVal == 32'hBEEF, "R9", dataVal, 32'hBEEF);
    doReq(0, 0, 2, 7, 16'h0);               // R2 foreign node
    doReq(3, 0, HOME, 7, 16'h0);            // R2 type none
    doReq(1, 2, HOME, 5, 16'h0);            // R4 uncached write
    doReq(0, 1, HOME, 7, 16'h0);            // R2 state unchanged
    chk(dataVal == 7, "R2", dataVal, 7);

    // constrained random
    for (int n = 0; n < 600; n++) begin
      kind = $urandom % 4;
      if (kind == 3 && ($urandom % 3) != 0) kind = $urandom % 2;
      src  = $urandom % NP;
      blk  = $urandom % 4;
      node = (($urandom % 10) == 0) ? 2 : HOME;
      if (kind == 2 && mState[blk] == 2 && ($urandom % 2) == 0) src = ownerOf(mPres[blk]);
      doReq(kind, src, node, blk, 16'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule